// File: doc/BRIEF.md
# Static Memory Read Cycle Sequencer

This block runs one read access on an external asynchronous static memory bus. The host raises a request with a byte address and a set of byte lanes. The block then drives the memory address and byte-lane outputs for a programmed number of clock cycles. Within that cycle it lowers an active-low read strobe and an active-low chip select. Each of these two strobes has its own programmed lead-in, low time and trailing time.

At the clock edge on which the read strobe returns high, the block samples the memory data bus. It presents the sampled word on its read-data output together with a one-cycle completion pulse. The device width selects how the byte address is placed on the address outputs. All timing values are counted in clock cycles. They are captured when a request is accepted, so the host may change them while a cycle is running.

Top module: `sram_read_sequencer`

## Requirements
- R1: While reset is high and in the first cycle after it, `mem_rd_n` and `mem_cs_n` are 1, and `busy` and `done` are 0.
- R2: A request seen while `busy` is 0 is accepted at that clock edge. From the next cycle, `busy` stays 1 for exactly C cycles, where C is `cfg_cycle`, or 1 when `cfg_cycle` is 0. `mem_addr` and `mem_be` (a copy of `req_be`) take their new values together in the first busy cycle and hold them for the whole access.
- R3: The address placed on `mem_addr` depends on `cfg_dev_width`. Code 0 (8-bit device) outputs `req_addr` unchanged. Code 1 (16-bit device) outputs it with bit 0 forced to 0. Codes 2 and 3 (32-bit device) output it with bits 1 and 0 forced to 0.
- R4: Busy cycles are numbered k = 0 .. C-1. The read strobe `mem_rd_n` is 0 exactly when S <= k < S+P, where S = min(`cfg_rd_setup`, C-1) and P = min(max(`cfg_rd_pulse`, 1), C-S). Outside busy cycles it is 1.
- R5: `mem_cs_n` follows the rule of R4, computed independently from `cfg_cs_setup` and `cfg_cs_pulse`.
- R6: `rdata` takes the value that `mem_data` had in the last cycle in which `mem_rd_n` was 0. `done` is 1 for exactly the one cycle that follows that last low cycle, and `rdata` holds its value until the next capture.
- R7: A request that arrives while `busy` is 1 is ignored. The running access keeps its length, address and strobe timing.
- R8: Changes to any `cfg_*` input while `busy` is 1 do not affect the running access.
- R9: A read or chip-select pulse count of 0 gives a strobe that is low for exactly one cycle.
- R10: When setup plus pulse exceeds C, the strobe low time is cut short so that it ends with the last busy cycle. A setup of C or more is reduced to C-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_dev_width | input | 2 | Device width code: 0 = 8-bit, 1 = 16-bit, 2 or 3 = 32-bit |
| cfg_cycle | input | CNT_W | Total access length in cycles (0 is treated as 1) |
| cfg_rd_setup | input | CNT_W | Cycles from the start of the access to the read strobe going low |
| cfg_rd_pulse | input | CNT_W | Read strobe low time in cycles |
| cfg_cs_setup | input | CNT_W | Cycles from the start of the access to the chip select going low |
| cfg_cs_pulse | input | CNT_W | Chip select low time in cycles |
| req | input | 1 | Start a read access (taken only when idle) |
| req_addr | input | ADDR_W | Byte address of the access |
| req_be | input | BE_W | Byte lanes enabled for the access |
| busy | output | 1 | An access is in progress |
| done | output | 1 | One-cycle pulse: `rdata` has been updated |
| rdata | output | DATA_W | Captured read data |
| mem_addr | output | ADDR_W | Memory address bus |
| mem_be | output | BE_W | Memory byte-lane selects |
| mem_rd_n | output | 1 | Active-low read strobe |
| mem_cs_n | output | 1 | Active-low chip select |
| mem_data | input | DATA_W | Memory data bus |

## Verification
Some properties are checked by assertions on every cycle. Both strobes stay high while idle. The address does not move during an access, and the cycle counter never reaches the latched length. A busy request never restarts the counter. The read strobe's rising edge always coincides with `done`, and `done` never lasts two cycles. Every loaded strobe window is non-empty. The exact cycle placement of each strobe cannot be shown by these local properties. Neither can the clamping of oversized settings, the address layout for each width, or the latching of the configuration. A behavioural model in the bench checks all of these in scenarios that change the width code, use zero pulses, use oversized setup counts, hold the request high and reprogram the configuration during an access.

// File: rtl/srd_pkg.sv
package srd_pkg;

  typedef enum logic [1:0] {
    DW_8   = 2'd0,
    DW_16  = 2'd1,
    DW_32  = 2'd2,
    DW_32X = 2'd3
  } dev_width_e;

  localparam int NUM_STROBES = 2;
  localparam int STB_RD      = 0;
  localparam int STB_CS      = 1;

endpackage

// File: rtl/srd_addr_fmt.sv
module srd_addr_fmt
  import srd_pkg::*;
#(
  parameter int ADDR_W = 26
) (
  input  logic [1:0]        dev_width,
  input  logic [ADDR_W-1:0] byte_addr,
  output logic [ADDR_W-1:0] bus_addr
);

  always_comb begin
    bus_addr = byte_addr;
    unique case (dev_width_e'(dev_width))
      DW_8:    bus_addr = byte_addr;
      DW_16:   bus_addr[0] = 1'b0;
      default: bus_addr[1:0] = 2'b00;
    endcase
  end

endmodule

// File: rtl/srd_window_calc.sv
module srd_window_calc #(
  parameter int CNT_W = 6
) (
  input  logic [CNT_W-1:0] eff_cycle,
  input  logic [CNT_W-1:0] setup,
  input  logic [CNT_W-1:0] pulse,
  output logic [CNT_W-1:0] win_start,
  output logic [CNT_W-1:0] win_end
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] pulse_min;
  logic [CNT_W-1:0] room;
  logic [CNT_W-1:0] pulse_fit;

  always_comb begin
    win_start = (setup >= eff_cycle) ? (eff_cycle - ONE) : setup;
    pulse_min = (pulse == '0) ? ONE : pulse;
    room      = eff_cycle - win_start;
    pulse_fit = (pulse_min > room) ? room : pulse_min;
    win_end   = win_start + pulse_fit;
  end

endmodule

// File: rtl/srd_strobe_win.sv
module srd_strobe_win #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             active_nxt,
  input  logic [CNT_W-1:0] cnt_nxt,
  input  logic [CNT_W-1:0] win_start,
  input  logic [CNT_W-1:0] win_end,
  output logic             strobe_n,
  output logic             closing
);

  logic [CNT_W-1:0] start_q;
  logic [CNT_W-1:0] end_q;
  logic [CNT_W-1:0] start_use;
  logic [CNT_W-1:0] end_use;
  logic             low_nxt;

  assign start_use = load ? win_start : start_q;
  assign end_use   = load ? win_end   : end_q;
  assign low_nxt   = active_nxt && (cnt_nxt >= start_use) && (cnt_nxt < end_use);
  assign closing   = !strobe_n && !low_nxt;

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q  <= '0;
      end_q    <= '0;
      strobe_n <= 1'b1;
    end else begin
      if (load) begin
        start_q <= win_start;
        end_q   <= win_end;
      end
      strobe_n <= !low_nxt;
    end
  end

  // R9: every window handed over on a request spans at least one cycle
  p_window_nonempty_r9: assert property (@(posedge clk) disable iff (rst)
    load |-> (win_end > win_start));

  // R4: a strobe that goes low was opened inside a non-empty latched window
  p_low_inside_window_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(strobe_n) |-> (end_q > start_q));

endmodule

// File: rtl/sram_read_sequencer.sv
module sram_read_sequencer
  import srd_pkg::*;
#(
  parameter int ADDR_W = 26,
  parameter int DATA_W = 32,
  parameter int BE_W   = 4,
  parameter int CNT_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        cfg_dev_width,
  input  logic [CNT_W-1:0]  cfg_cycle,
  input  logic [CNT_W-1:0]  cfg_rd_setup,
  input  logic [CNT_W-1:0]  cfg_rd_pulse,
  input  logic [CNT_W-1:0]  cfg_cs_setup,
  input  logic [CNT_W-1:0]  cfg_cs_pulse,
  input  logic              req,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [BE_W-1:0]   req_be,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [BE_W-1:0]   mem_be,
  output logic              mem_rd_n,
  output logic              mem_cs_n,
  input  logic [DATA_W-1:0] mem_data
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic              busy_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  cyc_q;
  logic [ADDR_W-1:0] addr_q;
  logic [BE_W-1:0]   be_q;
  logic [DATA_W-1:0] rdata_q;
  logic              done_q;

  logic              accept;
  logic              last;
  logic              active_nxt;
  logic [CNT_W-1:0]  cnt_nxt;
  logic [CNT_W-1:0]  eff_cyc;
  logic [ADDR_W-1:0] fmt_addr;

  logic [CNT_W-1:0]       set_v   [NUM_STROBES];
  logic [CNT_W-1:0]       pul_v   [NUM_STROBES];
  logic [CNT_W-1:0]       win_s   [NUM_STROBES];
  logic [CNT_W-1:0]       win_e   [NUM_STROBES];
  logic [NUM_STROBES-1:0] stb_n;
  logic [NUM_STROBES-1:0] stb_close;

  assign accept     = !busy_q && req;
  assign last       = busy_q && (cnt_q == (cyc_q - ONE));
  assign active_nxt = accept || (busy_q && !last);
  assign cnt_nxt    = accept ? '0 : (cnt_q + ONE);
  assign eff_cyc    = (cfg_cycle == '0) ? ONE : cfg_cycle;

  assign set_v[STB_RD] = cfg_rd_setup;
  assign pul_v[STB_RD] = cfg_rd_pulse;
  assign set_v[STB_CS] = cfg_cs_setup;
  assign pul_v[STB_CS] = cfg_cs_pulse;

  srd_addr_fmt #(.ADDR_W(ADDR_W)) u_addr_fmt (
    .dev_width (cfg_dev_width),
    .byte_addr (req_addr),
    .bus_addr  (fmt_addr)
  );

  for (genvar g = 0; g < NUM_STROBES; g++) begin : g_stb
    srd_window_calc #(.CNT_W(CNT_W)) u_calc (
      .eff_cycle (eff_cyc),
      .setup     (set_v[g]),
      .pulse     (pul_v[g]),
      .win_start (win_s[g]),
      .win_end   (win_e[g])
    );
    srd_strobe_win #(.CNT_W(CNT_W)) u_win (
      .clk        (clk),
      .rst        (rst),
      .load       (accept),
      .active_nxt (active_nxt),
      .cnt_nxt    (cnt_nxt),
      .win_start  (win_s[g]),
      .win_end    (win_e[g]),
      .strobe_n   (stb_n[g]),
      .closing    (stb_close[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      cnt_q   <= '0;
      cyc_q   <= ONE;
      addr_q  <= '0;
      be_q    <= '0;
      rdata_q <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= stb_close[STB_RD];
      if (stb_close[STB_RD]) rdata_q <= mem_data;
      if (accept) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
        cyc_q  <= eff_cyc;
        addr_q <= fmt_addr;
        be_q   <= req_be;
      end else if (busy_q) begin
        if (last) busy_q <= 1'b0;
        else      cnt_q  <= cnt_nxt;
      end
    end
  end

  assign busy     = busy_q;
  assign done     = done_q;
  assign rdata    = rdata_q;
  assign mem_addr = addr_q;
  assign mem_be   = be_q;
  assign mem_rd_n = stb_n[STB_RD];
  assign mem_cs_n = stb_n[STB_CS];

  // R4 / R5: both strobes stay high outside an access
  p_idle_strobes_high_r4: assert property (@(posedge clk) disable iff (rst)
    !busy_q |-> (mem_rd_n && mem_cs_n));

  // R2: address and byte lanes are frozen for the whole access
  p_addr_stable_r2: assert property (@(posedge clk) disable iff (rst)
    (busy_q && $past(busy_q)) |-> ($stable(mem_addr) && $stable(mem_be)));

  // R2: the cycle counter stays below the latched length
  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> (cnt_q < cyc_q));

  // R7: a running access only advances; a new request never restarts it
  p_no_restart_r7: assert property (@(posedge clk) disable iff (rst)
    (busy_q && $past(busy_q)) |-> (cnt_q == ($past(cnt_q) + ONE)));

  // R6: data is presented exactly when the read strobe rises
  p_capture_on_rise_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_rd_n) |-> done);

  // R6: completion is a single-cycle pulse
  p_done_single_r6: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R5: once the chip-select window closes, the select is high on the next cycle
  p_cs_release_r5: assert property (@(posedge clk) disable iff (rst)
    stb_close[STB_CS] |=> mem_cs_n);

endmodule

// File: tb/sram_read_sequencer_bench.sv
module sram_read_sequencer_bench;

  localparam int ADDR_W = 26;
  localparam int DATA_W = 32;
  localparam int BE_W   = 4;
  localparam int CNT_W  = 6;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [1:0]        cfg_dev_width = 2'd2;
  logic [CNT_W-1:0]  cfg_cycle = '0;
  logic [CNT_W-1:0]  cfg_rd_setup = '0;
  logic [CNT_W-1:0]  cfg_rd_pulse = '0;
  logic [CNT_W-1:0]  cfg_cs_setup = '0;
  logic [CNT_W-1:0]  cfg_cs_pulse = '0;
  logic              req = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [BE_W-1:0]   req_be = '0;
  logic              busy;
  logic              done;
  logic [DATA_W-1:0] rdata;
  logic [ADDR_W-1:0] mem_addr;
  logic [BE_W-1:0]   mem_be;
  logic              mem_rd_n;
  logic              mem_cs_n;
  logic [DATA_W-1:0] mem_data = '0;

  int checks = 0;
  int fails  = 0;
  bit cmp_en = 1'b0;
  string scen = "reset";

  always #5 clk = ~clk;

  sram_read_sequencer #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BE_W(BE_W), .CNT_W(CNT_W)
  ) u_sram_read_sequencer (
    .clk(clk), .rst(rst), .cfg_dev_width(cfg_dev_width), .cfg_cycle(cfg_cycle),
    .cfg_rd_setup(cfg_rd_setup), .cfg_rd_pulse(cfg_rd_pulse),
    .cfg_cs_setup(cfg_cs_setup), .cfg_cs_pulse(cfg_cs_pulse),
    .req(req), .req_addr(req_addr), .req_be(req_be),
    .busy(busy), .done(done), .rdata(rdata), .mem_addr(mem_addr), .mem_be(mem_be),
    .mem_rd_n(mem_rd_n), .mem_cs_n(mem_cs_n), .mem_data(mem_data)
  );

  // ---------------- behavioural reference model ----------------
  int  m_k, m_c, m_rs, m_rp, m_cs, m_cp;
  bit  m_busy, m_rd_n, m_cs_n, m_done;
  longint m_addr, m_be, m_rdata;

  function automatic int clamp_start(int setup, int c);
    return (setup > c - 1) ? c - 1 : setup;
  endfunction

  function automatic int clamp_len(int pulse, int start, int c);
    int p;
    p = (pulse < 1) ? 1 : pulse;
    return (p > c - start) ? c - start : p;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_busy = 0; m_k = 0; m_done = 0; m_rdata = 0; m_addr = 0; m_be = 0;
      m_c = 1; m_rs = 0; m_rp = 1; m_cs = 0; m_cp = 1;
    end else begin
      m_done = 0;
      if (!m_busy) begin
        if (req) begin
          m_c  = (cfg_cycle == 0) ? 1 : int'(cfg_cycle);
          m_rs = clamp_start(int'(cfg_rd_setup), m_c);
          m_rp = clamp_len(int'(cfg_rd_pulse), m_rs, m_c);
          m_cs = clamp_start(int'(cfg_cs_setup), m_c);
          m_cp = clamp_len(int'(cfg_cs_pulse), m_cs, m_c);
          case (cfg_dev_width)
            2'd0:    m_addr = longint'(req_addr);
            2'd1:    m_addr = longint'(req_addr) & ~longint'(1);
            default: m_addr = longint'(req_addr) & ~longint'(3);
          endcase
          m_be = longint'(req_be);
          m_k = 0;
          m_busy = 1;
        end
      end else begin
        if (m_k == m_rs + m_rp - 1) begin
          m_rdata = longint'(mem_data);
          m_done = 1;
        end
        if (m_k == m_c - 1) m_busy = 0;
        else m_k = m_k + 1;
      end
    end
    m_rd_n = !(m_busy && m_k >= m_rs && m_k < m_rs + m_rp);
    m_cs_n = !(m_busy && m_k >= m_cs && m_k < m_cs + m_cp);
  end

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s [%s] %s: actual %0h expected %0h", rq, scen, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_en) begin
      chk(busy == m_busy, "R2", "busy", longint'(busy), longint'(m_busy));
      chk(longint'(mem_addr) == m_addr, "R3", "mem_addr", longint'(mem_addr), m_addr);
      chk(longint'(mem_be) == m_be, "R2", "mem_be", longint'(mem_be), m_be);
      chk(mem_rd_n == m_rd_n, "R4", "mem_rd_n", longint'(mem_rd_n), longint'(m_rd_n));
      chk(mem_cs_n == m_cs_n, "R5", "mem_cs_n", longint'(mem_cs_n), longint'(m_cs_n));
      chk(done == m_done, "R6", "done", longint'(done), longint'(m_done));
      chk(longint'(rdata) == m_rdata, "R6", "rdata", longint'(rdata), m_rdata);
    end
  end

  // data bus changes every cycle so the capture edge matters
  int dcnt = 0;
  always @(negedge clk) begin
    dcnt++;
    mem_data <= DATA_W'(dcnt) * 32'h9E3779B1;
  end

  // ---------------- stimulus ----------------
  task automatic do_read(input int w, input int a, input int be,
                         input int rs, input int rp, input int cs, input int cp,
                         input int cy, input bit hold_req, input bit chg_cfg,
                         output int rlow, output int clow, output int blen);
    cfg_dev_width = 2'(w);
    cfg_rd_setup = CNT_W'(rs); cfg_rd_pulse = CNT_W'(rp);
    cfg_cs_setup = CNT_W'(cs); cfg_cs_pulse = CNT_W'(cp);
    cfg_cycle = CNT_W'(cy);
    req_addr = ADDR_W'(a); req_be = BE_W'(be);
    req = 1'b1;
    @(negedge clk);
    if (!hold_req) req = 1'b0;
    if (chg_cfg) begin
      cfg_rd_setup = CNT_W'(0); cfg_rd_pulse = CNT_W'(30);
      cfg_cs_setup = CNT_W'(4); cfg_cs_pulse = CNT_W'(1);
      cfg_cycle = CNT_W'(40); cfg_dev_width = 2'd0;
      req_addr = ADDR_W'(a + 1);
    end
    rlow = 0; clow = 0; blen = 0;
    while (busy) begin
      if (!mem_rd_n) rlow++;
      if (!mem_cs_n) clow++;
      blen++;
      @(negedge clk);
    end
    req = 1'b0;
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int rl, cl, bl;
    repeat (3) @(negedge clk);
    // R1: outputs during reset
    chk(mem_rd_n && mem_cs_n && !busy && !done, "R1", "reset outputs",
        longint'({mem_rd_n, mem_cs_n, busy, done}), 64'hC);
    rst = 1'b0;
    @(negedge clk);
    chk(mem_rd_n && mem_cs_n && !busy && !done, "R1", "after reset",
        longint'({mem_rd_n, mem_cs_n, busy, done}), 64'hC);
    cmp_en = 1'b1;

    scen = "R4 basic 32-bit";
    do_read(2, 'h12345F, 4'hF, 2, 3, 1, 5, 8, 0, 0, rl, cl, bl);
    chk(rl == 3, "R4", "read low cycles", rl, 3);
    chk(cl == 5, "R5", "cs low cycles", cl, 5);
    chk(bl == 8, "R2", "busy length", bl, 8);

    scen = "R3 16-bit";
    do_read(1, 'h2ABCD7, 4'h3, 0, 2, 0, 4, 5, 0, 0, rl, cl, bl);
    scen = "R3 8-bit";
    do_read(0, 'h1FFFF3, 4'h1, 1, 1, 0, 3, 4, 0, 0, rl, cl, bl);
    scen = "R3 code 3";
    do_read(3, 'h0F0F0E, 4'hC, 3, 2, 2, 2, 7, 0, 0, rl, cl, bl);

    scen = "R9 zero pulse";
    do_read(2, 'h4000, 4'hF, 1, 0, 2, 0, 6, 0, 0, rl, cl, bl);
    chk(rl == 1, "R9", "read low with pulse 0", rl, 1);
    chk(cl == 1, "R9", "cs low with pulse 0", cl, 1);

    scen = "R10 pulse overrun";
    do_read(2, 'h8000, 4'hF, 5, 9, 6, 20, 8, 0, 0, rl, cl, bl);
    chk(rl == 3, "R10", "clamped read low", rl, 3);
    chk(cl == 2, "R10", "clamped cs low", cl, 2);
    scen = "R10 setup overrun";
    do_read(2, 'h8100, 4'hF, 10, 2, 60, 1, 4, 0, 0, rl, cl, bl);
    chk(rl == 1, "R10", "setup clamp read low", rl, 1);
    chk(bl == 4, "R2", "busy length", bl, 4);

    scen = "R2 zero cycle";
    do_read(2, 'h9000, 4'h5, 0, 0, 0, 0, 0, 0, 0, rl, cl, bl);
    chk(bl == 1, "R2", "cycle 0 length", bl, 1);
    chk(rl == 1, "R4", "cycle 0 read low", rl, 1);

    scen = "R7 held request";
    do_read(2, 'hA000, 4'hF, 1, 2, 0, 5, 5, 1, 0, rl, cl, bl);
    chk(bl == 5, "R7", "busy length with req held", bl, 5);
    chk(rl == 2, "R7", "read low with req held", rl, 2);

    scen = "R8 config change";
    do_read(2, 'hB004, 4'hF, 1, 2, 2, 3, 6, 0, 1, rl, cl, bl);
    chk(bl == 6, "R8", "busy length after cfg change", bl, 6);
    chk(rl == 2, "R8", "read low after cfg change", rl, 2);
    chk(cl == 3, "R8", "cs low after cfg change", cl, 3);

    scen = "R6 back to back";
    for (int i = 0; i < 20; i++) begin
      do_read(i % 4, 'h1000 + i * 37, i % 16, i % 5, i % 4, (i * 3) % 7, i % 6,
              (i * 7) % 13, 0, 0, rl, cl, bl);
    end

    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule